// File: doc/BRIEF.md
# MDIO Management Controller (Clause 22)

This block lets software reach external Ethernet PHY registers over a two-wire management bus. Software writes a single 32-bit command word that names the PHY, the register, the direction and, for a write, the value. The controller then produces the management clock, shifts the frame out and turns the data line around for reads. The finished result goes back into the same word: a busy flag, a read-valid flag and the 16 captured bits.

When a transfer finishes, the controller sets a sticky done-cause bit. A mask bit decides whether that cause reaches the interrupt pin. Software can therefore either poll the busy flag or sleep until the interrupt arrives. The register bus is a plain single-cycle select/write strobe with a combinational read path. The management clock is the system clock divided by a fixed parameter.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the command word, the cause word and the mask word all read as zero. MDC is low, MDIO is not driven and `irq` is low.
- R2: The command word is at offset 0x00. Its fields are: data in bits 15:0, PHY address in bits 20:16, register address in bits 25:21, operation in bit 26 (1 = read, 0 = write), read-valid in bit 27 and busy in bit 28. Bits 31:29 read as zero. A write to the command word while idle starts a frame, and busy reads 1 from the next cycle.
- R3: A frame is sent in this order: `PRE_BITS` ones, then start 01, then opcode 01 for a write or 10 for a read. Next come the 5-bit PHY address, the 5-bit register address and two turnaround bits (10 on a write). The frame ends with 16 data bits. Every field goes out MSB first.
- R4: MDC is low while idle and each of its half periods lasts `DIV_HALF` system cycles. MDIO changes only at MDC falling edges, and busy stays high for exactly 2·(`PRE_BITS`+32)·`DIV_HALF` cycles.
- R5: A command-word write while busy is ignored. The frame in flight and the command fields that read back both stay those of the first command.
- R6: On a read, MDIO is released from the first turnaround bit to the end of the frame. On a write, every bit of the frame is driven.
- R7: A read whose second turnaround bit is sampled as 0 sets read-valid. Bits 15:0 then hold the 16 bits sampled on MDC rising edges. A write never sets read-valid.
- R8: A read whose second turnaround bit is sampled as 1 leaves read-valid clear.
- R9: Read-valid is cleared in the cycle after a new command is accepted.
- R10: The cause word is at offset 0x7C. Its bit 4 is set when any operation completes, and all its other bits read as zero.
- R11: Writing the cause word with bit 4 at 0 clears the cause. Writing it with bit 4 at 1 leaves the cause unchanged. A completion in the same cycle as a clear wins.
- R12: The mask word is at offset 0x80, with bit 4 readable and writable. `irq` is high exactly when both the cause bit and the mask bit are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | Write qualifier for `reg_sel` |
| reg_addr | input | ADDR_W | Byte offset of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line output enable |
| mdio_in | input | 1 | Data line as seen at the pad |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the controller with `DIV_HALF` = 2 and `PRE_BITS` = 8. A whole frame therefore takes 160 cycles, which leaves room for a table of writes and read-backs, an absent-PHY read, commands issued while busy and every cause and mask combination. The busy-length check is an exact cycle count, and the turnaround bit positions shift with `PRE_BITS`. Together these show that the divider, the frame length and the release point follow the parameters and are not fixed constants.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;
  // Field positions inside the command word; software depends on them.
  localparam int unsigned DATA_LSB  = 0;
  localparam int unsigned PHY_LSB   = 16;
  localparam int unsigned REGAD_LSB = 21;
  localparam int unsigned OP_RD_BIT = 26;
  localparam int unsigned RDVAL_BIT = 27;
  localparam int unsigned BUSY_BIT  = 28;
  localparam int unsigned DONE_BIT  = 4;

  localparam logic [7:0] OFS_CMD   = 8'h00;
  localparam logic [7:0] OFS_CAUSE = 8'h7C;
  localparam logic [7:0] OFS_MASK  = 8'h80;

  typedef struct packed {
    logic       rd;
    logic [4:0] regad;
    logic [4:0] phy;
    logic [15:0] data;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_rst_sync.sv
`timescale 1ns/1ps
module mdio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
module mdio_clk_div #(
  parameter int unsigned DIV_HALF = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tk,
  output logic fall_tk
);
  localparam int unsigned CW = $clog2(DIV_HALF + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  assign wrap    = (cnt_q == CW'(DIV_HALF - 1));
  assign rise_tk = run & wrap & ~mdc_q;
  assign fall_tk = run & wrap &  mdc_q;
  assign mdc     = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  // R4: the clock parks low whenever no frame is running
  p_mdc_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned PRE_BITS = 32
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  mdio_cmd_t start_cmd,
  input  logic      rise_tk,
  input  logic      fall_tk,
  input  logic      mdio_in,
  output mdio_cmd_t cur_cmd,
  output logic      busy,
  output logic      done,
  output logic      rd_valid,
  output logic      mdio_out,
  output logic      mdio_oe
);
  localparam int unsigned FB      = PRE_BITS + 32;
  localparam int unsigned IW      = $clog2(FB);
  localparam int unsigned TA1_IDX = PRE_BITS + 14;
  localparam int unsigned TA2_IDX = PRE_BITS + 15;
  localparam int unsigned DAT_IDX = PRE_BITS + 16;

  logic          busy_q, busy_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [FB-1:0] sreg_q, sreg_d;
  mdio_cmd_t     cmd_q, cmd_d;
  logic          ta_ok_q, ta_ok_d;
  logic          valid_q, valid_d;
  logic          oe_q, oe_d;
  logic          last;
  logic          upd;
  logic [FB-1:0] frame_img;

  assign frame_img = {{PRE_BITS{1'b1}}, 2'b01,
                      (start_cmd.rd ? 2'b10 : 2'b01),
                      start_cmd.phy, start_cmd.regad,
                      (start_cmd.rd ? 2'b11 : 2'b10),
                      start_cmd.data};

  assign last = (idx_q == IW'(FB - 1));
  assign upd  = start | busy_q;

  always_comb begin
    busy_d  = busy_q;
    idx_d   = idx_q;
    sreg_d  = sreg_q;
    cmd_d   = cmd_q;
    ta_ok_d = ta_ok_q;
    valid_d = valid_q;
    oe_d    = oe_q;
    if (!busy_q) begin
      if (start) begin
        busy_d  = 1'b1;
        idx_d   = '0;
        sreg_d  = frame_img;
        cmd_d   = start_cmd;
        ta_ok_d = 1'b0;
        valid_d = 1'b0;
        oe_d    = 1'b1;
      end
    end else begin
      if (rise_tk && cmd_q.rd) begin
        if (idx_q == IW'(TA2_IDX)) ta_ok_d = ~mdio_in;
        if (idx_q >= IW'(DAT_IDX)) cmd_d.data = {cmd_q.data[14:0], mdio_in};
      end
      if (fall_tk) begin
        if (last) begin
          busy_d  = 1'b0;
          oe_d    = 1'b0;
          valid_d = cmd_q.rd & ta_ok_q;
        end else begin
          idx_d  = idx_q + 1'b1;
          sreg_d = {sreg_q[FB-2:0], 1'b0};
          if (cmd_q.rd && idx_q == IW'(TA1_IDX - 1)) oe_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      sreg_q  <= '0;
      cmd_q   <= '0;
      ta_ok_q <= 1'b0;
      valid_q <= 1'b0;
      oe_q    <= 1'b0;
    end else if (upd) begin
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      sreg_q  <= sreg_d;
      cmd_q   <= cmd_d;
      ta_ok_q <= ta_ok_d;
      valid_q <= valid_d;
      oe_q    <= oe_d;
    end
  end

  assign cur_cmd  = cmd_q;
  assign busy     = busy_q;
  assign done     = busy_q & fall_tk & last;
  assign rd_valid = valid_q;
  assign mdio_out = sreg_q[FB-1];
  assign mdio_oe  = oe_q;

  // R4: the line only moves on a falling clock tick
  p_wire_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fall_tk) |=> ($stable(mdio_out) && $stable(mdio_oe)));
  // R7: a completed write never reports read data
  p_write_no_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cmd_q.rd) |=> !rd_valid);
endmodule

// File: rtl/mdio_done_irq.sv
`timescale 1ns/1ps
module mdio_done_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic cause_wr,
  input  logic cause_wbit,
  input  logic mask_wr,
  input  logic mask_wbit,
  output logic cause,
  output logic mask,
  output logic irq
);
  logic cause_q, cause_d;
  logic mask_q, mask_d;
  logic upd;

  assign upd = done | cause_wr | mask_wr;

  always_comb begin
    cause_d = cause_q;
    mask_d  = mask_q;
    if (done)                       cause_d = 1'b1;
    else if (cause_wr && !cause_wbit) cause_d = 1'b0;
    if (mask_wr) mask_d = mask_wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= 1'b0;
      mask_q  <= 1'b0;
    end else if (upd) begin
      cause_q <= cause_d;
      mask_q  <= mask_d;
    end
  end

  assign cause = cause_q;
  assign mask  = mask_q;
  assign irq   = cause_q & mask_q;

  p_done_sets_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cause_q);
  p_zero_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_wr && !cause_wbit && !done) |=> !cause_q);
  p_one_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_wr && cause_wbit && !done) |=> $stable(cause_q));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DIV_HALF = 25,
  parameter int unsigned PRE_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in,
  output logic              irq
);
  logic      rst_n_s;
  logic      hit_cmd, hit_cause, hit_mask;
  logic      wr_cmd, start;
  mdio_cmd_t new_cmd, cur;
  logic      busy, done, rd_valid;
  logic      rise_tk, fall_tk;
  logic      cause, mask;
  logic      unused_wbits;
  logic [31:0] rd_word;

  mdio_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_s(rst_n_s));

  assign hit_cmd   = (reg_addr == ADDR_W'(OFS_CMD));
  assign hit_cause = (reg_addr == ADDR_W'(OFS_CAUSE));
  assign hit_mask  = (reg_addr == ADDR_W'(OFS_MASK));
  assign wr_cmd    = reg_sel & reg_wr & hit_cmd;
  assign start     = wr_cmd & ~busy;

  assign new_cmd.rd    = reg_wdata[OP_RD_BIT];
  assign new_cmd.regad = reg_wdata[REGAD_LSB +: 5];
  assign new_cmd.phy   = reg_wdata[PHY_LSB +: 5];
  assign new_cmd.data  = reg_wdata[DATA_LSB +: 16];
  assign unused_wbits  = ^{reg_wdata[31:27]};

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk(clk), .rst_n(rst_n_s), .run(busy),
    .mdc(mdc), .rise_tk(rise_tk), .fall_tk(fall_tk));

  mdio_frame_seq #(.PRE_BITS(PRE_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .start(start), .start_cmd(new_cmd),
    .rise_tk(rise_tk), .fall_tk(fall_tk), .mdio_in(mdio_in),
    .cur_cmd(cur), .busy(busy), .done(done), .rd_valid(rd_valid),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe));

  mdio_done_irq u_irq (
    .clk(clk), .rst_n(rst_n_s), .done(done),
    .cause_wr(reg_sel & reg_wr & hit_cause), .cause_wbit(reg_wdata[DONE_BIT]),
    .mask_wr(reg_sel & reg_wr & hit_mask), .mask_wbit(reg_wdata[DONE_BIT]),
    .cause(cause), .mask(mask), .irq(irq));

  always_comb begin
    rd_word = '0;
    if (hit_cmd) begin
      rd_word[DATA_LSB +: 16] = cur.data;
      rd_word[PHY_LSB +: 5]   = cur.phy;
      rd_word[REGAD_LSB +: 5] = cur.regad;
      rd_word[OP_RD_BIT]      = cur.rd;
      rd_word[RDVAL_BIT]      = rd_valid;
      rd_word[BUSY_BIT]       = busy;
    end else if (hit_cause) begin
      rd_word[DONE_BIT] = cause;
    end else if (hit_mask) begin
      rd_word[DONE_BIT] = mask;
    end
  end

  assign reg_rdata = rd_word;

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    start |=> busy);
  p_hold_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_cmd && busy) |=> $stable({cur.rd, cur.regad, cur.phy}));
endmodule

// File: tb/test_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module test_mdio_mgmt_ctrl;
  localparam int DH  = 2;
  localparam int PRE = 8;
  localparam int FB  = PRE + 32;
  localparam logic [4:0]  PHY_ID = 5'd3;
  localparam logic [63:0] PMASK  = (64'd1 << PRE) - 64'd1;
  localparam int NV = 9;
  // {rd, phy, reg, data, expect_valid}
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 5'd3, 5'd1,  16'hA5C3, 1'b0},
    {1'b0, 5'd3, 5'd31, 16'h0001, 1'b0},
    {1'b0, 5'd3, 5'd0,  16'hFFFF, 1'b0},
    {1'b1, 5'd3, 5'd1,  16'hA5C3, 1'b1},
    {1'b1, 5'd3, 5'd31, 16'h0001, 1'b1},
    {1'b1, 5'd3, 5'd0,  16'hFFFF, 1'b1},
    {1'b1, 5'd7, 5'd1,  16'h0000, 1'b0},
    {1'b0, 5'd3, 5'd16, 16'h8000, 1'b0},
    {1'b1, 5'd3, 5'd16, 16'h8000, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic mdc, mdio_out, mdio_oe, mdio_in, irq;

  int checks = 0;
  int fails  = 0;
  logic cur_rd = 1'b0;

  always #4 clk = ~clk;

  mdio_mgmt_ctrl #(.ADDR_W(8), .DIV_HALF(DH), .PRE_BITS(PRE)) i_mdio_mgmt_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_sel(sel), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .mdc(mdc), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .mdio_in(mdio_in), .irq(irq));

  // PHY responder
  int rcnt = 0;
  int frames = 0;
  int oe_bad = 0;
  logic [63:0] hist = '0;
  logic pre_ok = 1'b0;
  logic [31:0] last_frame = '0;
  logic drv_en = 1'b0, drv_val = 1'b1;
  logic [15:0] shd = '0;
  logic [15:0] mem [32];

  assign mdio_in = drv_en ? drv_val : 1'b1;

  always @(posedge mdc) begin
    logic b;
    logic [63:0] h;
    if (mdio_oe !== ((cur_rd && rcnt >= PRE + 14) ? 1'b0 : 1'b1)) oe_bad++;
    b = mdio_oe ? mdio_out : mdio_in;
    h = {hist[62:0], b};
    hist = h;
    if (rcnt == FB - 1) begin
      last_frame = h[31:0];
      pre_ok = (((h >> 32) & PMASK) == PMASK);
      frames++;
      if (h[29:28] == 2'b01 && h[27:23] == PHY_ID) mem[h[22:18]] = h[15:0];
      rcnt = 0;
    end else begin
      rcnt++;
    end
  end

  always @(negedge mdc) begin
    if (rcnt == PRE + 15 && hist[12:11] == 2'b10 && hist[10:6] == PHY_ID) begin
      drv_en = 1'b1; drv_val = 1'b0; shd = mem[hist[5:1]];
    end else if (drv_en && rcnt >= PRE + 16) begin
      drv_val = shd[15 - (rcnt - PRE - 16)];
    end else if (rcnt == 0) begin
      drv_en = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0; addr = 8'h00; wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata; addr = 8'h00;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    #1;
    while (rdata[28] === 1'b1 && n < 20000) begin
      n++; @(negedge clk); #1;
    end
  endtask

  function automatic logic [31:0] cmdw(logic rd, logic [4:0] phy, logic [4:0] ra, logic [15:0] d);
    return {5'b0, rd, ra, phy, d};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int n, f0, ob0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(8'h00, r); chk("R1 cmd", r, 32'h0);
    bus_read(8'h7C, r); chk("R1 cause", r, 32'h0);
    bus_read(8'h80, r); chk("R1 mask", r, 32'h0);
    chk("R1 pins", {29'b0, mdc, mdio_oe, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      logic rd, ev;
      logic [4:0] phy, ra;
      logic [15:0] dat;
      v = VEC[i]; rd = v[27]; phy = v[26:22]; ra = v[21:17]; dat = v[16:1]; ev = v[0];
      cur_rd = rd; f0 = frames; ob0 = oe_bad;
      bus_write(8'h00, cmdw(rd, phy, ra, dat));
      #1 chk("R2 busy and fields", {rdata[31:28], rdata[26:16]}, {4'b0001, rd, ra, phy});
      wait_idle(n);
      chk("R4 busy length", n, 2 * FB * DH);
      chk("R4 mdc idle", {31'b0, mdc}, 32'h0);
      chk("R3 one frame", frames, f0 + 1);
      chk("R3 preamble", {31'b0, pre_ok}, 32'h1);
      chk("R3 start/op/phy/reg", {16'b0, last_frame[31:18]},
          {16'b0, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra});
      if (!rd) chk("R3 ta and data", {14'b0, last_frame[17:0]}, {14'b0, 2'b10, dat});
      chk("R6 drive/release", oe_bad, ob0);
      bus_read(8'h00, r);
      chk("R2 busy clear", {31'b0, r[28]}, 32'h0);
      if (rd && ev)  chk("R7 read valid", {31'b0, r[27]}, 32'h1);
      if (rd && !ev) chk("R8 bad turnaround", {31'b0, r[27]}, 32'h0);
      if (!rd)       chk("R7 write no valid", {31'b0, r[27]}, 32'h0);
      if (rd && ev)  chk("R7 read data", {16'b0, r[15:0]}, {16'b0, dat});
      bus_read(8'h7C, r); chk("R10 cause set", r, 32'h10);
      bus_write(8'h7C, 32'h0);
      bus_read(8'h7C, r); chk("R11 cause cleared", r, 32'h0);
    end

    // R9: read-valid set by the last read, then cleared on new command
    bus_read(8'h00, r); chk("R9 valid before", {31'b0, r[27]}, 32'h1);
    cur_rd = 1'b0;
    bus_write(8'h00, cmdw(1'b0, 5'd3, 5'd4, 16'h0F0F));
    #1 chk("R9 valid cleared", {31'b0, rdata[27]}, 32'h0);
    wait_idle(n);

    // R12 / R11 interplay
    bus_read(8'h7C, r); chk("R10 cause after write", r, 32'h10);
    chk("R12 masked irq", {31'b0, irq}, 32'h0);
    bus_write(8'h80, 32'h10);
    chk("R12 irq on", {31'b0, irq}, 32'h1);
    bus_read(8'h80, r); chk("R12 mask read", r, 32'h10);
    bus_write(8'h7C, 32'hFFFF_FFFF);
    bus_read(8'h7C, r); chk("R11 one keeps", r, 32'h10);
    bus_write(8'h7C, 32'hFFFF_FFEF);
    bus_read(8'h7C, r); chk("R11 zero clears", r, 32'h0);
    chk("R12 irq off", {31'b0, irq}, 32'h0);
    bus_write(8'h80, 32'h0);
    bus_read(8'h80, r); chk("R12 mask cleared", r, 32'h0);

    // R5: second command during busy is dropped
    cur_rd = 1'b0; f0 = frames;
    bus_write(8'h00, cmdw(1'b0, 5'd3, 5'd2, 16'h1234));
    repeat (10) @(negedge clk);
    bus_write(8'h00, cmdw(1'b1, 5'd9, 5'd9, 16'hBEEF));
    wait_idle(n);
    repeat (4) @(negedge clk);
    chk("R5 one frame", frames, f0 + 1);
    chk("R5 wire data", {16'b0, last_frame[15:0]}, 32'h1234);
    chk("R5 wire reg", {27'b0, last_frame[22:18]}, 32'd2);
    bus_read(8'h00, r);
    chk("R5 fields kept", {5'b0, r[26:0]}, {5'b0, 1'b0, 5'd2, 5'd3, 16'h1234});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule